// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block sits between a cartridge's configuration registers and its memory chips. From four 5-bit configuration words (a control word, two character bank words and a program bank word) and the live CPU and PPU address lines, it produces three groups of outputs. The first group is the upper program-memory address bits. The second is the upper character-memory address bits. The third is the nametable RAM A10 line and the enables for program ROM and work RAM. It holds no state. It reacts to its inputs in the same time step, so it can sit directly in the address path. Whatever loads the registers lives outside this block.

The control word is split into three fields. Bits 1:0 choose nametable mirroring. Bits 3:2 choose how program memory is banked. Bit 4 selects one of two character layouts: a single 8 KB window, or two independent 4 KB windows picked by PPU A12. In the program bank word, bit 4 switches work RAM off.

Top module: `bank_addr_decoder`

## Requirements
- R1: With control bits 1:0 = 00, nt_a10 is 0. With 01, nt_a10 is 1. PPU A10 and A11 have no effect in either case.
- R2: With control bits 1:0 = 10, nt_a10 equals ppu_a10. With 11, nt_a10 equals ppu_a11.
- R3: With control bit 3 = 0 (32 KB mode), prg_addr_hi[3:1] equals program word bits 3:1 and prg_addr_hi[0] equals cpu_a14. Here prg_addr_hi bit 0 is A14 and bit 3 is A17.
- R4: With control bits 3:2 = 10, prg_addr_hi is 0 when cpu_a14 = 0, and equals program word bits 3:0 when cpu_a14 = 1.
- R5: With control bits 3:2 = 11, prg_addr_hi is 4'hF when cpu_a14 = 1, and equals program word bits 3:0 when cpu_a14 = 0.
- R6: With control bit 4 = 0, chr_addr_hi[4:1] equals character word 0 bits 4:1 and chr_addr_hi[0] equals ppu_a12. Here chr_addr_hi bit 0 is A12 and bit 4 is A16.
- R7: With control bit 4 = 1, chr_addr_hi equals character word 0 when ppu_a12 = 0, and equals character word 1 when ppu_a12 = 1.
- R8: prg_ce_n (active low) is 0 exactly when rom_sel_n is 0.
- R9: wram_ce (active high) is 1 exactly when rom_sel_n = 1, cpu_a14 = 1, cpu_a13 = 1 and program word bit 4 = 0.
- R10: cpu_rw has no effect on any output.
- R11: With control bit 4 = 0, character word 1 has no effect on chr_addr_hi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl_reg | input | 5 | Control word: mirroring [1:0], program mode [3:2], character 4 KB mode [4] |
| chr_lo_reg | input | 5 | Character bank word 0 (8 KB bank, or lower 4 KB window) |
| chr_hi_reg | input | 5 | Character bank word 1 (upper 4 KB window) |
| prg_reg | input | 5 | Program bank [3:0], work-RAM disable [4] |
| cpu_a13 | input | 1 | CPU address bit 13 |
| cpu_a14 | input | 1 | CPU address bit 14 |
| rom_sel_n | input | 1 | Active-low cartridge ROM select from the console |
| cpu_rw | input | 1 | CPU read/write strobe (ignored) |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| ppu_a12 | input | 1 | PPU address bit 12 |
| prg_addr_hi | output | 4 | Program memory A17..A14 (bit 0 = A14) |
| prg_ce_n | output | 1 | Program ROM chip enable, active low |
| wram_ce | output | 1 | Work RAM chip enable, active high |
| chr_addr_hi | output | 5 | Character memory A16..A12 (bit 0 = A12) |
| nt_a10 | output | 1 | Nametable RAM A10 |

## Verification
Several functions can change in the same cycle because some inputs feed more than one of them. When cpu_a14 toggles, the program bank can flip between the fixed half and the switchable half while the work-RAM enable changes too. When PPU A12 toggles in 4 KB mode, the character bank changes in the same cycle as any mirroring output that follows PPU A10 or A11. The bench applies vectors that move the control word, the address lines and rom_sel_n all at once. A monitor then compares every output field of each vector against its own model, so a wrong field blames the right requirement even when its neighbours changed in the same cycle.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;

    localparam int REG_W      = 5;
    localparam int PRG_BANK_W = 4;
    localparam int CHR_BANK_W = 5;

    typedef enum logic [1:0] {
        MIR_LOW  = 2'b00,
        MIR_HIGH = 2'b01,
        MIR_VERT = 2'b10,
        MIR_HORZ = 2'b11
    } mirror_e;

    typedef enum logic [1:0] {
        PRG_WIDE_A    = 2'b00,
        PRG_WIDE_B    = 2'b01,
        PRG_FIX_FIRST = 2'b10,
        PRG_FIX_LAST  = 2'b11
    } prg_mode_e;

    // Field order matters: the mirroring field sits at bits 1:0,
    // the program mode at 3:2 and the 4 KB flag at bit 4.
    typedef struct packed {
        logic      chr_4k;
        prg_mode_e prg_mode;
        mirror_e   mirror;
    } ctrl_t;

    typedef struct packed {
        logic a14;
        logic a13;
        logic rom_sel_n;
    } cpu_bus_t;

    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] raw);
        return ctrl_t'(raw);
    endfunction

    function automatic logic is_wide(input prg_mode_e m);
        return (m == PRG_WIDE_A) || (m == PRG_WIDE_B);
    endfunction

endpackage

// File: rtl/prg_map.sv
module prg_map
    import bank_dec_pkg::*;
#(
    parameter int BANK_W = PRG_BANK_W
) (
    input  prg_mode_e         mode,
    input  logic [BANK_W-1:0] bank_word,
    input  logic              cpu_a14,
    output logic [BANK_W-1:0] bank
);

    always_comb begin
        logic [BANK_W-1:0] b;
        unique case (mode)
            PRG_FIX_FIRST: b = cpu_a14 ? bank_word : '0;
            PRG_FIX_LAST:  b = cpu_a14 ? '1 : bank_word;
            default:       b = {bank_word[BANK_W-1:1], cpu_a14};
        endcase
        bank = b;

        // R3
        if (is_wide(mode))
            prg_wide_lsb_chk: assert (b[0] == cpu_a14 && b[BANK_W-1:1] == bank_word[BANK_W-1:1]);
        // R4
        if (mode == PRG_FIX_FIRST && !cpu_a14)
            prg_fix_first_chk: assert (b == '0);
        // R5
        if (mode == PRG_FIX_LAST && cpu_a14)
            prg_fix_last_chk: assert (&b);
    end

endmodule

// File: rtl/chr_map.sv
module chr_map
    import bank_dec_pkg::*;
#(
    parameter int BANK_W = CHR_BANK_W
) (
    input  logic              chr_4k,
    input  logic [BANK_W-1:0] lo_word,
    input  logic [BANK_W-1:0] hi_word,
    input  logic              ppu_a12,
    output logic [BANK_W-1:0] bank
);

    always_comb begin
        logic [BANK_W-1:0] b;
        if (chr_4k)
            b = ppu_a12 ? hi_word : lo_word;
        else
            b = {lo_word[BANK_W-1:1], ppu_a12};
        bank = b;

        // R6
        if (!chr_4k)
            chr_8k_chk: assert (b[0] == ppu_a12 && b[BANK_W-1:1] == lo_word[BANK_W-1:1]);
        // R7
        if (chr_4k && !ppu_a12)
            chr_4k_low_chk: assert (b == lo_word);
    end

endmodule

// File: rtl/nt_map.sv
module nt_map
    import bank_dec_pkg::*;
(
    input  mirror_e mirror,
    input  logic    ppu_a10,
    input  logic    ppu_a11,
    output logic    nt_a10
);

    always_comb begin
        logic v;
        unique case (mirror)
            MIR_LOW:  v = 1'b0;
            MIR_HIGH: v = 1'b1;
            MIR_VERT: v = ppu_a10;
            default:  v = ppu_a11;
        endcase
        nt_a10 = v;

        // R1
        if (mirror == MIR_LOW || mirror == MIR_HIGH)
            nt_fixed_chk: assert (v == mirror[0]);
    end

endmodule

// File: rtl/enable_dec.sv
module enable_dec
    import bank_dec_pkg::*;
(
    input  cpu_bus_t bus,
    input  logic     wram_off,
    output logic     prg_ce_n,
    output logic     wram_ce
);

    always_comb begin
        logic rom_n;
        logic ram;
        rom_n = bus.rom_sel_n;
        ram   = bus.rom_sel_n & bus.a14 & bus.a13 & ~wram_off;
        prg_ce_n = rom_n;
        wram_ce  = ram;

        // R8
        enables_exclusive_chk: assert (!(ram && !rom_n));
        // R9
        if (wram_off)
            wram_off_chk: assert (!ram);
    end

endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
    import bank_dec_pkg::*;
(
    input  logic [REG_W-1:0]      ctrl_reg,
    input  logic [REG_W-1:0]      chr_lo_reg,
    input  logic [REG_W-1:0]      chr_hi_reg,
    input  logic [REG_W-1:0]      prg_reg,
    input  logic                  cpu_a13,
    input  logic                  cpu_a14,
    input  logic                  rom_sel_n,
    input  logic                  cpu_rw,
    input  logic                  ppu_a10,
    input  logic                  ppu_a11,
    input  logic                  ppu_a12,
    output logic [PRG_BANK_W-1:0] prg_addr_hi,
    output logic                  prg_ce_n,
    output logic                  wram_ce,
    output logic [CHR_BANK_W-1:0] chr_addr_hi,
    output logic                  nt_a10
);

    ctrl_t    ctrl;
    cpu_bus_t bus;
    logic     unused_rw;

    assign ctrl      = unpack_ctrl(ctrl_reg);
    assign bus       = '{a14: cpu_a14, a13: cpu_a13, rom_sel_n: rom_sel_n};
    assign unused_rw = cpu_rw;

    prg_map #(.BANK_W(PRG_BANK_W)) u_prg (
        .mode      (ctrl.prg_mode),
        .bank_word (prg_reg[PRG_BANK_W-1:0]),
        .cpu_a14   (cpu_a14),
        .bank      (prg_addr_hi)
    );

    chr_map #(.BANK_W(CHR_BANK_W)) u_chr (
        .chr_4k  (ctrl.chr_4k),
        .lo_word (chr_lo_reg[CHR_BANK_W-1:0]),
        .hi_word (chr_hi_reg[CHR_BANK_W-1:0]),
        .ppu_a12 (ppu_a12),
        .bank    (chr_addr_hi)
    );

    nt_map u_nt (
        .mirror  (ctrl.mirror),
        .ppu_a10 (ppu_a10),
        .ppu_a11 (ppu_a11),
        .nt_a10  (nt_a10)
    );

    enable_dec u_en (
        .bus      (bus),
        .wram_off (prg_reg[REG_W-1]),
        .prg_ce_n (prg_ce_n),
        .wram_ce  (wram_ce)
    );

endmodule

// File: tb/bank_addr_decoder_bench.sv
module bank_addr_decoder_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] ctrl_reg = '0, chr_lo_reg = '0, chr_hi_reg = '0, prg_reg = '0;
    logic       cpu_a13 = 0, cpu_a14 = 0, rom_sel_n = 0, cpu_rw = 0;
    logic       ppu_a10 = 0, ppu_a11 = 0, ppu_a12 = 0;
    logic [3:0] prg_addr_hi;
    logic       prg_ce_n, wram_ce, nt_a10;
    logic [4:0] chr_addr_hi;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    bank_addr_decoder u_bank_addr_decoder (
        .ctrl_reg(ctrl_reg), .chr_lo_reg(chr_lo_reg), .chr_hi_reg(chr_hi_reg),
        .prg_reg(prg_reg), .cpu_a13(cpu_a13), .cpu_a14(cpu_a14),
        .rom_sel_n(rom_sel_n), .cpu_rw(cpu_rw), .ppu_a10(ppu_a10),
        .ppu_a11(ppu_a11), .ppu_a12(ppu_a12), .prg_addr_hi(prg_addr_hi),
        .prg_ce_n(prg_ce_n), .wram_ce(wram_ce), .chr_addr_hi(chr_addr_hi),
        .nt_a10(nt_a10)
    );

    typedef struct {
        logic [3:0] prg;
        logic [4:0] chr;
        logic       nt;
        logic       ce_n;
        logic       wram;
        string      t_prg;
        string      t_chr;
        string      t_nt;
        string      tag_all;
    } item_t;

    item_t sb[$];

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver: applies one vector after a rising edge, pushes its expectation.
    task automatic apply(input logic [4:0] c, input logic [4:0] l, input logic [4:0] h,
                         input logic [4:0] p, input logic a13, input logic a14,
                         input logic rs, input logic rw, input logic [2:0] ppu,
                         input string tag);
        item_t it;
        @(posedge clk);
        #1;
        ctrl_reg = c; chr_lo_reg = l; chr_hi_reg = h; prg_reg = p;
        cpu_a13 = a13; cpu_a14 = a14; rom_sel_n = rs; cpu_rw = rw;
        ppu_a10 = ppu[0]; ppu_a11 = ppu[1]; ppu_a12 = ppu[2];
        // model written from the requirements
        if (c[3] == 1'b0) begin
            it.prg = (p[3:0] & 4'hE) | {3'b000, a14};
            it.t_prg = "R3";
        end else if (c[2] == 1'b0) begin
            it.prg = a14 ? p[3:0] : 4'h0;
            it.t_prg = "R4";
        end else begin
            it.prg = a14 ? 4'hF : p[3:0];
            it.t_prg = "R5";
        end
        if (c[4]) begin
            it.chr = ppu[2] ? h : l;
            it.t_chr = "R7";
        end else begin
            it.chr = (l & 5'h1E) | {4'b0000, ppu[2]};
            it.t_chr = "R6";
        end
        case (c[1:0])
            2'd0: it.nt = 1'b0;
            2'd1: it.nt = 1'b1;
            2'd2: it.nt = ppu[0];
            default: it.nt = ppu[1];
        endcase
        it.t_nt = c[1] ? "R2" : "R1";
        it.ce_n = rs;
        it.wram = (rs && a14 && a13 && !p[4]);
        it.tag_all = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares at the falling edge, away from input changes.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            if (it.tag_all != "") begin
                check({it.tag_all, " prg"}, prg_addr_hi, it.prg);
                check({it.tag_all, " chr"}, chr_addr_hi, it.chr);
                check({it.tag_all, " nt"}, nt_a10, it.nt);
                check({it.tag_all, " ce"}, prg_ce_n, it.ce_n);
                check({it.tag_all, " wram"}, wram_ce, it.wram);
            end else begin
                check(it.t_prg, prg_addr_hi, it.prg);
                check(it.t_chr, chr_addr_hi, it.chr);
                check(it.t_nt, nt_a10, it.nt);
                check("R8", prg_ce_n, it.ce_n);
                check("R9", wram_ce, it.wram);
            end
        end
    end

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // reset state: all-zero inputs give all-zero outputs
        apply(5'h00, 5'h00, 5'h00, 5'h00, 0, 0, 0, 0, 3'b000, "reset R3 R6 R1 R8");
        rst = 1'b0;
        // R1: fixed mirroring ignores PPU A10/A11
        apply(5'h00, 5'h00, 5'h00, 5'h00, 0, 0, 1, 0, 3'b011, "R1");
        apply(5'h01, 5'h00, 5'h00, 5'h00, 0, 0, 1, 0, 3'b000, "R1");
        // R2: follow PPU A10 / A11
        apply(5'h02, 5'h00, 5'h00, 5'h00, 0, 0, 1, 0, 3'b001, "R2");
        apply(5'h03, 5'h00, 5'h00, 5'h00, 0, 0, 1, 0, 3'b010, "R2");
        // R3: 32 KB mode
        apply(5'h00, 5'h00, 5'h00, 5'h0B, 0, 1, 0, 0, 3'b000, "R3");
        // R4 / R5 at both halves, with A14 moving together with the RAM enable
        apply(5'h08, 5'h00, 5'h00, 5'h07, 1, 0, 1, 0, 3'b000, "R4");
        apply(5'h08, 5'h00, 5'h00, 5'h07, 1, 1, 1, 0, 3'b000, "R4 R9");
        apply(5'h0C, 5'h00, 5'h00, 5'h05, 1, 1, 1, 0, 3'b000, "R5 R9");
        apply(5'h0C, 5'h00, 5'h00, 5'h05, 1, 0, 1, 0, 3'b000, "R5");
        // R9: work RAM disabled by program word bit 4
        apply(5'h00, 5'h00, 5'h00, 5'h10, 1, 1, 1, 0, 3'b000, "R9");
        // R6 / R7 / R11
        apply(5'h00, 5'h15, 5'h0A, 5'h00, 0, 0, 0, 0, 3'b100, "R6");
        apply(5'h10, 5'h15, 5'h0A, 5'h00, 0, 0, 0, 0, 3'b100, "R7");
        apply(5'h10, 5'h15, 5'h0A, 5'h00, 0, 0, 0, 0, 3'b000, "R7");
        apply(5'h00, 5'h15, 5'h1F, 5'h00, 0, 0, 0, 0, 3'b000, "R11");
        apply(5'h00, 5'h15, 5'h00, 5'h00, 0, 0, 0, 0, 3'b000, "R11");
        // R10: toggling R/W alone changes nothing
        apply(5'h1E, 5'h09, 5'h12, 5'h06, 1, 1, 1, 0, 3'b101, "R10");
        apply(5'h1E, 5'h09, 5'h12, 5'h06, 1, 1, 1, 1, 3'b101, "R10");
        // mixed vectors: every field may move at once
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            apply(r[4:0], r[9:5], r[14:10], r[19:15], r[20], r[21], r[22], r[23],
                  r[26:24], "");
        end
        @(posedge clk);
        @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule